// File: doc/BRIEF.md
# Mode Code Legality Checker for a 1553 Remote Terminal

This block sits behind the word decoder of a MIL-STD-1553 remote terminal. When a received command word has been validated, its fields (terminal address, transmit/receive bit, subaddress and word count/mode code) are presented on the command inputs together with a one-cycle `cmd_valid` strobe. The block decides whether the command is a mode code. If it is, the block decides whether that mode code is legal for this terminal. It returns a single-cycle response that carries the mode code flag, the illegal command flag, the 5-bit mode code number and the transmit/receive bit.

Legality is set in layers. Codes that the standard leaves undefined or reserved are always illegal. Codes that must never be broadcast are illegal when they arrive on the broadcast address. Every other defined code can be marked illegal, one code at a time, by an external one-bit-wide programmable lookup memory. That memory is slow: up to 200 ns access time against a 12 MHz clock. The block therefore holds the lookup address steady for a number of clock cycles derived from its parameters before it samples the returned bit. A strap input turns the memory off. With the strap low, every defined code is legal and the memory is never read.

The controller is a three-state machine. `ST_IDLE` waits for a command. The transition `IDLE->REPORT` is taken for a non-mode command, for a code that is rejected without a lookup, or when the strap is low. The transition `IDLE->LOOKUP` is taken when the memory must be consulted. `ST_LOOKUP` drives the memory address and read enable until the wait timer expires, then takes `LOOKUP->REPORT`. `ST_REPORT` raises `rsp_valid` for one cycle and always returns through `REPORT->IDLE`.

Top module: `mode_code_legality`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `cmd_ready` is 1, `rsp_valid` is 0 and `tbl_rd_en` is 0.
- R2: A command is a mode code exactly when its subaddress is 0 or 31. Any other subaddress gives `rsp_mode`=0 and `rsp_illegal`=0, with `rsp_valid` in the cycle after the capturing edge.
- R3: The defined codes are 0-8, 16, 18 and 19 with transmit/receive=1, and 17, 20 and 21 with transmit/receive=0. Any other code/direction pair gives `rsp_illegal`=1 whatever the memory holds, and the memory is not read.
- R4: When the terminal address is 31 (broadcast), codes 0, 2, 16, 18 and 19 give `rsp_illegal`=1 without a memory read. The remaining defined codes stay subject to the memory.
- R5: The lookup address is 7 bits wide. Bit 6 is the transmit/receive bit, bit 5 is 1 when the subaddress is 31, and bits 4:0 are the mode code.
- R6: During a lookup, `tbl_rd_en` stays high for exactly WAIT_CYC cycles (3 at 200 ns and 12 MHz), and `tbl_addr` stays stable throughout. The memory bit is sampled at the edge that ends this window, and `rsp_valid` follows in the next cycle, four cycles after the capturing edge.
- R7: For a defined code that is permitted on its address, with the strap high, `rsp_illegal` equals the memory bit (1 = illegal).
- R8: With `illeg_en` low at capture, every defined code that is permitted on its address gives `rsp_illegal`=0. `tbl_rd_en` never rises, and the response comes in the cycle after capture.
- R9: `cmd_valid` is ignored while `cmd_ready` is 0. No extra response is produced, and the response in progress keeps the fields of the first command.
- R10: `rsp_valid` is a one-cycle pulse. `rsp_code` and `rsp_tr` echo the word count/mode code field and the transmit/receive bit of the captured command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a validated command |
| cmd_ready | output | 1 | High when a new command can be taken |
| cmd_addr | input | 5 | Terminal address field of the command |
| cmd_tr | input | 1 | Transmit/receive bit (1 = transmit) |
| cmd_subaddr | input | 5 | Subaddress/mode field |
| cmd_wc_mc | input | 5 | Word count / mode code field |
| illeg_en | input | 1 | Strap: 1 = consult the lookup memory |
| tbl_addr | output | 7 | Lookup memory address |
| tbl_rd_en | output | 1 | Lookup memory read enable |
| tbl_data | input | 1 | Lookup memory output, 1 = illegal |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_mode | output | 1 | Command was a mode code |
| rsp_illegal | output | 1 | Command is illegal |
| rsp_code | output | 5 | Mode code number |
| rsp_tr | output | 1 | Transmit/receive bit of the command |

## Verification
The assertions check, on every cycle, the properties that hold locally. The lookup address must not move while a read is open, and a read window must end in a response. The response must be a one-cycle pulse, and no command may be taken while a read is open. A non-mode response must never be flagged illegal, and a reserved code from 22 up must always be flagged illegal. The remaining behaviours depend on what the command carried and on when the memory data became valid. These are the exact read-window length, broadcast rejection, the strap bypass and the legality bit taken from memory. Only the bench can show them, because its memory model returns the wrong bit until the address has been held for the full window, and its reference model computes the legality independently.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    localparam int FIELD_W = 5;
    localparam int LUT_AW  = FIELD_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REPORT = 2'd2
    } mcl_state_e;

endpackage

// File: rtl/mcl_decode.sv
module mcl_decode
    import mcl_pkg::*;
(
    input  logic [FIELD_W-1:0] addr,
    input  logic               tr,
    input  logic [FIELD_W-1:0] sa,
    input  logic [FIELD_W-1:0] mc,
    output logic               is_mode,
    output logic               sa_hi,
    output logic               is_bcast,
    output logic               defined,
    output logic               bcast_ok
);

    int code;

    assign sa_hi    = &sa;
    assign is_mode  = (sa == '0) || sa_hi;
    assign is_bcast = &addr;

    always_comb begin
        code     = 32'(mc);
        defined  = 1'b0;
        bcast_ok = 1'b0;
        if (tr) begin
            // transmit-direction codes
            defined  = (code <= 8) || (code == 16) || (code == 18) || (code == 19);
            bcast_ok = (code == 1) || ((code >= 3) && (code <= 8));
        end else begin
            // receive-direction codes carry a data word
            defined  = (code == 17) || (code == 20) || (code == 21);
            bcast_ok = defined;
        end
    end

endmodule

// File: rtl/mcl_wait_timer.sv
module mcl_wait_timer #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mode_code_legality.sv
module mode_code_legality
    import mcl_pkg::*;
#(
    parameter int ACCESS_NS = 200,
    parameter int CLK_KHZ   = 12000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [FIELD_W-1:0] cmd_addr,
    input  logic               cmd_tr,
    input  logic [FIELD_W-1:0] cmd_subaddr,
    input  logic [FIELD_W-1:0] cmd_wc_mc,
    input  logic               illeg_en,
    output logic [LUT_AW-1:0]  tbl_addr,
    output logic               tbl_rd_en,
    input  logic               tbl_data,
    output logic               rsp_valid,
    output logic               rsp_mode,
    output logic               rsp_illegal,
    output logic [FIELD_W-1:0] rsp_code,
    output logic               rsp_tr
);

    // cycles needed to cover the memory access time, rounded up
    localparam int WAIT_RAW = (ACCESS_NS * CLK_KHZ + 999999) / 1000000;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    mcl_state_e state, state_n;

    logic is_mode, sa_hi, is_bcast, defined, bcast_ok;
    logic pre_illegal, need_lookup, wait_done, take;
    logic [LUT_AW-1:0] look_addr;

    mcl_decode u_decode (
        .addr     (cmd_addr),
        .tr       (cmd_tr),
        .sa       (cmd_subaddr),
        .mc       (cmd_wc_mc),
        .is_mode  (is_mode),
        .sa_hi    (sa_hi),
        .is_bcast (is_bcast),
        .defined  (defined),
        .bcast_ok (bcast_ok)
    );

    mcl_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_LOOKUP),
        .done  (wait_done)
    );

    assign take        = cmd_valid && (state == ST_IDLE);
    assign pre_illegal = is_mode && (!defined || (is_bcast && !bcast_ok));
    assign need_lookup = is_mode && !pre_illegal && illeg_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) state_n = need_lookup ? ST_LOOKUP : ST_REPORT;
            ST_LOOKUP: if (wait_done) state_n = ST_REPORT;
            ST_REPORT: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // result and lookup address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_mode    <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_code    <= '0;
            rsp_tr      <= 1'b0;
            look_addr   <= '0;
        end else if (take) begin
            rsp_mode    <= is_mode;
            rsp_illegal <= pre_illegal;
            rsp_code    <= cmd_wc_mc;
            rsp_tr      <= cmd_tr;
            look_addr   <= {cmd_tr, sa_hi, cmd_wc_mc};
        end else if ((state == ST_LOOKUP) && wait_done) begin
            rsp_illegal <= tbl_data;
        end
    end

    assign tbl_addr  = look_addr;
    assign tbl_rd_en = (state == ST_LOOKUP);
    assign rsp_valid = (state == ST_REPORT);
    assign cmd_ready = (state == ST_IDLE);

endmodule

// File: rtl/mcl_props.sv
module mcl_props
    import mcl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_ready,
    input logic [LUT_AW-1:0]  tbl_addr,
    input logic               tbl_rd_en,
    input logic               rsp_valid,
    input logic               rsp_mode,
    input logic               rsp_illegal,
    input logic [FIELD_W-1:0] rsp_code
);

    // R2
    p_nonmode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_mode |-> !rsp_illegal);

    // R3
    p_reserved_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_mode && (rsp_code >= 5'd22) |-> rsp_illegal);

    // R6
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en && $past(tbl_rd_en) |-> $stable(tbl_addr));

    // R6
    p_read_ends_in_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tbl_rd_en) |-> rsp_valid);

    // R9
    p_busy_during_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> !cmd_ready);

    // R10
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind mode_code_legality mcl_props u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .tbl_addr    (tbl_addr),
    .tbl_rd_en   (tbl_rd_en),
    .rsp_valid   (rsp_valid),
    .rsp_mode    (rsp_mode),
    .rsp_illegal (rsp_illegal),
    .rsp_code    (rsp_code)
);

// File: tb/mode_code_legality_tb.sv
module mode_code_legality_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_ready;
    logic [4:0] cmd_addr;
    logic       cmd_tr;
    logic [4:0] cmd_subaddr;
    logic [4:0] cmd_wc_mc;
    logic       illeg_en;
    logic [6:0] tbl_addr;
    logic       tbl_rd_en;
    logic       tbl_data;
    logic       rsp_valid;
    logic       rsp_mode;
    logic       rsp_illegal;
    logic [4:0] rsp_code;
    logic       rsp_tr;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    mode_code_legality u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_tr(cmd_tr), .cmd_subaddr(cmd_subaddr),
        .cmd_wc_mc(cmd_wc_mc), .illeg_en(illeg_en), .tbl_addr(tbl_addr),
        .tbl_rd_en(tbl_rd_en), .tbl_data(tbl_data), .rsp_valid(rsp_valid),
        .rsp_mode(rsp_mode), .rsp_illegal(rsp_illegal), .rsp_code(rsp_code),
        .rsp_tr(rsp_tr)
    );

    // slow memory model: wrong data until the address has been held long enough
    logic [127:0] imap;
    logic [6:0]   prev_a;
    int           stab;

    always @(posedge clk) begin
        prev_a <= tbl_addr;
        if (!tbl_rd_en)                         stab <= 0;
        else if (stab > 0 && tbl_addr == prev_a) stab <= stab + 1;
        else                                    stab <= 1;
    end
    assign tbl_data = (stab >= 2) ? imap[tbl_addr] : ~imap[tbl_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit f_defined(input bit t, input int m);
        if (t) return (m <= 8) || m == 16 || m == 18 || m == 19;
        return m == 17 || m == 20 || m == 21;
    endfunction

    function automatic bit f_bcast_bad(input bit t, input int m);
        return t && (m == 0 || m == 2 || m == 16 || m == 18 || m == 19);
    endfunction

    task automatic run_cmd(input logic [4:0] a, input logic t, input logic [4:0] s,
                           input logic [4:0] m, input logic e, input bit poke);
        bit   mode, rej, look, exp_ill;
        int   lat, rds, exp_lat;
        logic [6:0] seen_a, exp_a;
        mode    = (s == 5'd0) || (s == 5'd31);
        rej     = mode && (!f_defined(t, int'(m)) || (a == 5'd31 && f_bcast_bad(t, int'(m))));
        look    = mode && !rej && e;
        exp_a   = {t, (s == 5'd31), m};
        exp_ill = rej ? 1'b1 : (look ? imap[exp_a] : 1'b0);
        exp_lat = look ? 4 : 1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_tr = t; cmd_subaddr = s;
        cmd_wc_mc = m; illeg_en = e;
        lat = 0; rds = 0; seen_a = '0;
        do begin
            @(negedge clk);
            lat++;
            cmd_valid = (poke && lat == 1) ? 1'b1 : 1'b0;
            if (poke && lat == 1) begin
                cmd_subaddr = 5'd7; cmd_tr = ~t; cmd_wc_mc = ~m;
            end
            if (tbl_rd_en) begin rds++; seen_a = tbl_addr; end
        end while (!rsp_valid && lat < 20);
        cmd_valid = 1'b0;
        chk(lat == exp_lat, "R6/R8 response latency", lat, exp_lat);
        chk(rds == (look ? 3 : 0), "R6/R3/R8 read cycles", rds, look ? 3 : 0);
        if (look) chk(seen_a == exp_a, "R5 lookup address", seen_a, exp_a);
        chk(rsp_mode == mode, "R2 mode flag", rsp_mode, mode);
        chk(rsp_illegal == exp_ill, "R3/R4/R7 illegal flag", rsp_illegal, exp_ill);
        chk(rsp_code == m && rsp_tr == t, "R10 echoed fields",
            {rsp_tr, rsp_code}, {t, m});
        @(negedge clk);
        chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);
        if (poke) begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (rsp_valid) extra++;
            end
            chk(extra == 0, "R9 ignored strobe made no response", extra, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h1553);
        for (int i = 0; i < 4; i++) imap[i*32 +: 32] = $urandom;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_tr = 1'b0;
        cmd_subaddr = '0; cmd_wc_mc = '0; illeg_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !rsp_valid && !tbl_rd_en, "R1 reset state",
            {cmd_ready, rsp_valid, tbl_rd_en}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !rsp_valid && !tbl_rd_en, "R1 after release",
            {cmd_ready, rsp_valid, tbl_rd_en}, 3'b100);

        // directed corners
        imap[7'b1_0_01001] = 1'b0;
        run_cmd(5'd3, 1'b1, 5'd0, 5'd9, 1'b1, 0);          // R3 reserved transmit code
        run_cmd(5'd3, 1'b1, 5'd31, 5'd17, 1'b1, 0);        // R3 code 17 in wrong direction
        run_cmd(5'd3, 1'b0, 5'd0, 5'd25, 1'b1, 0);         // R3 high reserved
        run_cmd(5'd31, 1'b1, 5'd0, 5'd2, 1'b1, 0);         // R4 broadcast tx status
        run_cmd(5'd31, 1'b1, 5'd0, 5'd19, 0, 0);           // R4 even with strap low
        imap[7'b1_0_00001] = 1'b0;
        run_cmd(5'd31, 1'b1, 5'd0, 5'd1, 1'b1, 0);         // R4/R7 broadcast sync legal
        imap[7'b0_1_10001] = 1'b1;
        run_cmd(5'd4, 1'b0, 5'd31, 5'd17, 1'b1, 0);        // R5/R7 illegal from memory
        imap[7'b1_0_00010] = 1'b1;
        run_cmd(5'd4, 1'b1, 5'd0, 5'd2, 1'b0, 0);          // R8 bypass ignores memory
        run_cmd(5'd4, 1'b1, 5'd0, 5'd2, 1'b1, 1);          // R7 and R9 stray strobe
        run_cmd(5'd4, 1'b1, 5'd12, 5'd2, 1'b1, 0);         // R2 non-mode

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [4:0] a, s, m;
            logic t, e;
            int r;
            r = $urandom_range(0, 9);
            s = (r < 4) ? 5'd0 : (r < 7) ? 5'd31 : 5'($urandom);
            a = ($urandom_range(0, 9) < 3) ? 5'd31 : 5'($urandom);
            m = 5'($urandom);
            t = 1'($urandom);
            e = ($urandom_range(0, 3) != 0);
            run_cmd(a, t, s, m, e, ($urandom_range(0, 19) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule